// File: doc/BRIEF.md
# DRAM Rank Boundary Decoder

This block turns a physical address into a DRAM rank selection for a memory controller with two channels of four ranks each. Software programs one 8-bit cumulative boundary per rank and a 3-bit page-size attribute per rank through a small write port. The decoder compares the address's 32 MiB unit (address bits from 25 upward) with the effective boundaries. It reports whether the address falls in populated memory, which channel and rank it belongs to, and the page-size code of that rank.

The block also works out, from the register contents alone, whether the two channels are populated identically. When they are, the channels run interleaved. Only channel 0's boundaries are then used, each doubled because the two channels together hold twice that amount, and the channel comes from address bit 7, just above the 128-byte line. When the channels differ, channel 1's ranks sit in the address space directly above the top of channel 0. Every output is registered, so a result appears one clock after its address.

Top module: `rank_bound_decoder`

## Requirements
- R1: While reset is held, every output is 0 and every register is cleared. After reset, with nothing written, every address misses and the interleave flag reads 1, because the two all-zero channels match.
- R2: A write with `wr_sel_i` 0..3 loads the boundary of channel 0 rank 0..3, and 4..7 loads channel 1 ranks 0..3. Selector 8 holds channel 0's attributes for ranks 0/1, selector 9 channel 0's ranks 2/3, and 10 and 11 the same pairs for channel 1. A write takes effect on the clock edge where it is presented.
- R3: In non-interleaved mode the effective boundaries are ch0[0..3] followed by ch0[3]+ch1[0..3]. The selection is the lowest of these eight whose value is strictly greater than `addr_i[33:25]`. An index of 0..3 gives channel 0 and 4..7 gives channel 1.
- R4: A rank whose effective boundary equals the previous rank's boundary (or 0 for the first rank) is never selected.
- R5: When no effective boundary is greater than the address unit, `hit_o` is 0 and `chan_o`, `rank_o` and `page_o` are 0.
- R6: `ilv_o` is 1 exactly when all four boundaries match between the channels and every 3-bit attribute field (bits 2:0 for the even rank, bits 6:4 for the odd rank) matches. Bits 3 and 7 of the attribute registers are ignored.
- R7: In interleaved mode the effective boundary of rank i is 2×ch0[i] for i = 0..3. `chan_o` equals `addr_i[7]`, and channel 1's ranks are never selected on their own.
- R8: On a hit, `page_o` is the attribute field of the selected channel and rank. Codes: 000 unpopulated, 010 4 KB, 011 8 KB, 100 16 KB; any other code is passed through unchanged.
- R9: The outputs are registered. A change of `addr_i` shows on the outputs only after the next rising clock edge.
- R10: Writes with `wr_sel_i` 12..15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register selector |
| wr_data_i | input | 8 | Write data |
| addr_i | input | 34 | Physical address to decode |
| hit_o | output | 1 | Address falls in populated memory |
| ilv_o | output | 1 | Channels are interleaved |
| chan_o | output | 1 | Selected channel |
| rank_o | output | 2 | Selected rank within the channel |
| page_o | output | 3 | Page-size code of the selected rank |

## Verification
Every one of the 512 address units is swept under four programmings, and the bench model predicts each result arithmetically from the values written. The first is non-interleaved with empty ranks in both channels, which separates the lowest-strictly-greater rule and the channel 1 offset from off-by-one compares. The second is interleaved with the largest boundary, swept with address bit 7 at both values, which tests doubling, the 9-bit carry and the channel bit. The third and fourth each differ from a matching setup in exactly one attribute field or one boundary, which shows that the interleave detection looks at every field and ignores the reserved bits. Further short tests cover the reset state, the one-cycle latency and writes to unused selectors.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int ATTR_REG_W = 8;
  localparam int FIELD_W    = 3;
  localparam int EVEN_LSB   = 0;
  localparam int ODD_LSB    = 4;

  // Page-size code of one rank within a two-rank attribute register.
  function automatic logic [FIELD_W-1:0] rank_field(input logic [ATTR_REG_W-1:0] reg_v,
                                                    input logic odd);
    return odd ? reg_v[ODD_LSB +: FIELD_W] : reg_v[EVEN_LSB +: FIELD_W];
  endfunction
endpackage

// File: rtl/rbd_regs.sv
module rbd_regs #(
  parameter int RANKS = 4,
  parameter int BND_W = 8,
  parameter int SEL_W = 4
) (
  input  logic                                           clk_i,
  input  logic                                           rst_i,
  input  logic                                           wr_en_i,
  input  logic [SEL_W-1:0]                               wr_sel_i,
  input  logic [BND_W-1:0]                               wr_data_i,
  output logic [1:0][RANKS-1:0][BND_W-1:0]               bnd_o,
  output logic [1:0][RANKS/2-1:0][rbd_pkg::ATTR_REG_W-1:0] attr_o
);
  localparam int PAIRS  = RANKS / 2;
  localparam int NB     = 2 * RANKS;
  localparam int NREGS  = NB + 2 * PAIRS;

  logic [1:0][RANKS-1:0][BND_W-1:0]                bnd_q;
  logic [1:0][PAIRS-1:0][rbd_pkg::ATTR_REG_W-1:0]  attr_q;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    for (genvar r = 0; r < RANKS; r++) begin : g_bnd
      always_ff @(posedge clk_i) begin
        if (rst_i)
          bnd_q[ch][r] <= '0;
        else if (wr_en_i && wr_sel_i == SEL_W'(ch * RANKS + r))
          bnd_q[ch][r] <= wr_data_i;
      end
    end
    for (genvar p = 0; p < PAIRS; p++) begin : g_attr
      always_ff @(posedge clk_i) begin
        if (rst_i)
          attr_q[ch][p] <= '0;
        else if (wr_en_i && wr_sel_i == SEL_W'(NB + ch * PAIRS + p))
          attr_q[ch][p] <= wr_data_i[rbd_pkg::ATTR_REG_W-1:0];
      end
    end
  end

  assign bnd_o  = bnd_q;
  assign attr_o = attr_q;

  // R2: a boundary write lands on the next edge
  assert_wr_bnd_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_sel_i == SEL_W'(RANKS)) |=> (bnd_q[1][0] == $past(wr_data_i)));

  // R10: writes to unused selectors touch no register
  assert_unused_sel_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && int'(wr_sel_i) >= NREGS) |=> ($stable(bnd_q) && $stable(attr_q)));
endmodule

// File: rtl/rbd_match.sv
module rbd_match #(
  parameter int RANKS = 4,
  parameter int BND_W = 8
) (
  input  logic [1:0][RANKS-1:0][BND_W-1:0]                 bnd_i,
  input  logic [1:0][RANKS/2-1:0][rbd_pkg::ATTR_REG_W-1:0] attr_i,
  output logic                                             ilv_o
);
  logic [RANKS-1:0] same_rank;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    logic [rbd_pkg::FIELD_W-1:0] f0, f1;
    assign f0 = rbd_pkg::rank_field(attr_i[0][r/2], 1'(r % 2));
    assign f1 = rbd_pkg::rank_field(attr_i[1][r/2], 1'(r % 2));
    assign same_rank[r] = (bnd_i[0][r] == bnd_i[1][r]) && (f0 == f1);
  end

  assign ilv_o = &same_rank;
endmodule

// File: rtl/rbd_select.sv
module rbd_select #(
  parameter int RANKS  = 4,
  parameter int BND_W  = 8,
  parameter int UNIT_W = 9
) (
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic [1:0][RANKS-1:0][BND_W-1:0] bnd_i,
  input  logic                             ilv_i,
  input  logic [UNIT_W-1:0]                unit_i,
  output logic                             hit_o,
  output logic [$clog2(2*RANKS)-1:0]       idx_o
);
  localparam int NR    = 2 * RANKS;
  localparam int IDX_W = $clog2(NR);
  localparam int EFF_W = BND_W + 1;
  localparam int CMP_W = (UNIT_W > EFF_W) ? UNIT_W : EFF_W;

  logic [NR-1:0][CMP_W-1:0] eff;
  logic [NR-1:0]            above;
  logic [NR:0]              seen;
  logic [NR-1:0]            first;
  logic [CMP_W-1:0]         unit_x;

  assign unit_x = CMP_W'(unit_i);

  for (genvar j = 0; j < NR; j++) begin : g_eff
    if (j < RANKS) begin : g_lo
      assign eff[j] = ilv_i ? (CMP_W'(bnd_i[0][j]) << 1) : CMP_W'(bnd_i[0][j]);
    end else begin : g_hi
      assign eff[j] = ilv_i ? '0
                            : CMP_W'(bnd_i[0][RANKS-1]) + CMP_W'(bnd_i[1][j-RANKS]);
    end
    assign above[j] = eff[j] > unit_x;
  end

  assign seen[0] = 1'b0;
  for (genvar j = 0; j < NR; j++) begin : g_pri
    assign first[j]  = above[j] & ~seen[j];
    assign seen[j+1] = seen[j] | above[j];
  end

  always_comb begin
    idx_o = '0;
    for (int j = 0; j < NR; j++)
      if (first[j]) idx_o = idx_o | IDX_W'(j);
  end
  assign hit_o = seen[NR];

  logic [CMP_W-1:0] sel_eff, prev_eff;
  always_comb begin
    sel_eff  = eff[idx_o];
    prev_eff = (idx_o == '0) ? '0 : eff[idx_o - IDX_W'(1)];
  end

  // R3: the chosen boundary lies above the unit, the one before it does not
  assert_lowest_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (sel_eff > unit_x && prev_eff <= unit_x));

  // R4: an empty rank (boundary equal to its predecessor) is never picked
  assert_no_empty_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (sel_eff != prev_eff));
endmodule

// File: rtl/rank_bound_decoder.sv
module rank_bound_decoder #(
  parameter int ADDR_W      = 34,
  parameter int GRAIN_SHIFT = 25,
  parameter int RANKS       = 4,
  parameter int BND_W       = 8,
  parameter int CH_BIT      = 7,
  parameter int SEL_W       = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_i,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic [BND_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic                      hit_o,
  output logic                      ilv_o,
  output logic                      chan_o,
  output logic [$clog2(RANKS)-1:0]  rank_o,
  output logic [2:0]                page_o
);
  localparam int UNIT_W = ADDR_W - GRAIN_SHIFT;
  localparam int RANK_W = $clog2(RANKS);
  localparam int IDX_W  = $clog2(2 * RANKS);

  logic [1:0][RANKS-1:0][BND_W-1:0]                 bnd;
  logic [1:0][RANKS/2-1:0][rbd_pkg::ATTR_REG_W-1:0] attr;
  logic                                             ilv_c, hit_c, chan_c;
  logic [IDX_W-1:0]                                 idx_c;
  logic [RANK_W-1:0]                                rank_c;
  logic [2:0]                                       page_c;

  rbd_regs #(.RANKS(RANKS), .BND_W(BND_W), .SEL_W(SEL_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
    .wr_data_i(wr_data_i), .bnd_o(bnd), .attr_o(attr));

  rbd_match #(.RANKS(RANKS), .BND_W(BND_W)) u_match (
    .bnd_i(bnd), .attr_i(attr), .ilv_o(ilv_c));

  rbd_select #(.RANKS(RANKS), .BND_W(BND_W), .UNIT_W(UNIT_W)) u_sel (
    .clk_i(clk_i), .rst_i(rst_i), .bnd_i(bnd), .ilv_i(ilv_c),
    .unit_i(addr_i[ADDR_W-1:GRAIN_SHIFT]), .hit_o(hit_c), .idx_o(idx_c));

  always_comb begin
    rank_c = idx_c[RANK_W-1:0];
    chan_c = ilv_c ? addr_i[CH_BIT] : idx_c[IDX_W-1];
    page_c = rbd_pkg::rank_field(attr[chan_c][rank_c[RANK_W-1:1]], rank_c[0]);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hit_o  <= 1'b0;
      ilv_o  <= 1'b0;
      chan_o <= 1'b0;
      rank_o <= '0;
      page_o <= '0;
    end else begin
      hit_o  <= hit_c;
      ilv_o  <= ilv_c;
      chan_o <= hit_c ? chan_c : 1'b0;
      rank_o <= hit_c ? rank_c : '0;
      page_o <= hit_c ? page_c : '0;
    end
  end

  // R1: reset clears the outputs
  assert_reset_R1: assert property (@(posedge clk_i) rst_i |=> (!hit_o && !ilv_o));

  // R5: a miss reports zero selection
  assert_miss_zero_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit_o |-> (!chan_o && rank_o == '0 && page_o == '0));

  // R7: interleaved hits take the channel from the address line bit
  assert_ilv_chan_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (ilv_c && hit_c) |=> (chan_o == $past(addr_i[CH_BIT])));
endmodule

// File: tb/rank_bound_decoder_tb.sv
`timescale 1ns/1ps
module rank_bound_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [33:0] addr = '0;
  logic        hit, ilv, chan;
  logic [1:0]  rank;
  logic [2:0]  page;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // expected register contents, kept from what the bench wrote
  int mb [2][4];
  int ma [2][2];

  always #4 clk = ~clk;

  rank_bound_decoder u_dut (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .addr_i(addr), .hit_o(hit), .ilv_o(ilv),
    .chan_o(chan), .rank_o(rank), .page_o(page));

  function automatic int fld(int regv, int odd);
    return odd != 0 ? (regv >> 4) & 7 : regv & 7;
  endfunction

  // expected {hit, ilv, chan, rank, page} packed into 8 bits
  function automatic logic [7:0] model(logic [33:0] a);
    int unit = int'(a[33:25]);
    int eff [8];
    bit il = 1'b1;
    bit h = 1'b0;
    int c = 0, r = 0, pg = 0;
    for (int i = 0; i < 4; i++) begin
      if (mb[0][i] != mb[1][i]) il = 1'b0;
      if (fld(ma[0][i/2], i%2) != fld(ma[1][i/2], i%2)) il = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      if (il) eff[i] = (i < 4) ? 2 * mb[0][i] : 0;
      else    eff[i] = (i < 4) ? mb[0][i] : mb[0][3] + mb[1][i-4];
    end
    for (int i = 7; i >= 0; i--)
      if (eff[i] > unit) begin h = 1'b1; r = i % 4; c = il ? int'(a[7]) : i / 4; end
    if (h) pg = fld(ma[c][r/2], r%2);
    else begin c = 0; r = 0; end
    return {h, il, 1'(c), 2'(r), 3'(pg)};
  endfunction

  task automatic check(logic [7:0] exp, string tag);
    logic [7:0] act = {hit, ilv, chan, rank, page};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h act={hit,ilv,chan,rank,page}=%b exp=%b", tag, addr, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(int sel, int data);
    wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(data);
    if (sel < 8) mb[sel/4][sel%4] = data;
    else if (sel < 12) ma[(sel-8)/2][(sel-8)%2] = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(logic [33:0] a, string tag);
    addr = a;
    @(negedge clk);
    check(model(a), tag);
  endtask

  function automatic logic [33:0] mk(int unit, int b7);
    logic [24:0] low = 25'h15A_5A3C;
    low[7] = 1'(b7);
    return {9'(unit), low};
  endfunction

  task automatic sweep(int b7, string tag);
    for (int u = 0; u < 512; u++) look(mk(u, b7), tag);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 4; i++) mb[c][i] = 0;
      for (int i = 0; i < 2; i++) ma[c][i] = 0;
    end
    addr = mk(3, 0);
    repeat (3) @(negedge clk);
    check(8'h00, "R1 outputs in reset");
    rst = 1'b0;
    look(mk(0, 0), "R1 empty after reset");
    look(mk(511, 1), "R1 empty after reset");

    // non-interleaved: ch0 rank1 empty, ch1 ranks 1,2 empty
    wr(0, 4); wr(1, 4); wr(2, 10); wr(3, 16);
    wr(4, 8); wr(5, 8); wr(6, 8); wr(7, 20);
    wr(8, 8'h32); wr(9, 8'h04); wr(10, 8'h42); wr(11, 8'h03);
    sweep(0, "R3 R4 R5 R8 non-interleaved");
    sweep(1, "R3 R2 non-interleaved bit7 set");
    // R9: output holds until the next rising edge
    look(mk(12, 0), "R9 before change");
    addr = mk(40, 0);
    #2 check(model(mk(12, 0)), "R9 held before edge");
    @(negedge clk);
    check(model(mk(40, 0)), "R9 after edge");

    // interleaved: identical channels, reserved attribute bits differ, max boundary
    wr(0, 2); wr(1, 5); wr(2, 5); wr(3, 255);
    wr(4, 2); wr(5, 5); wr(6, 5); wr(7, 255);
    wr(8, 8'hA3); wr(9, 8'h24); wr(10, 8'h23); wr(11, 8'hAC);
    sweep(0, "R6 R7 R4 interleaved bit7=0");
    sweep(1, "R7 R8 interleaved bit7=1");

    // one odd-rank field differs -> non-interleaved
    wr(11, 8'h14);
    sweep(1, "R6 attribute field mismatch");

    // fields equal again, one boundary differs -> non-interleaved
    wr(11, 8'h24); wr(7, 250);
    sweep(0, "R6 boundary mismatch");

    // unused selectors must change nothing
    for (int s = 12; s < 16; s++) wr(s, 8'hFF);
    for (int u = 0; u < 512; u += 17) look(mk(u, u % 2), "R10 unused selector");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule